// File: doc/BRIEF.md
# Quarter-Table Multi-Channel Sine Synthesizer

This block produces several independent digital sine waves at once. Each channel owns a phase accumulator that advances by its own frequency word on every accepted output beat. The accumulator's upper bits pick one of four quadrants and address a table holding only the first quarter of a sine period. Mirroring the address in the second and fourth quarters, and negating the value in the second half, rebuilds the full period from that quarter table. The table is computed when the design is elaborated, so no stored contents are needed.

A shared phase-reset strobe, pulsed once per external trigger, puts every channel back at its own configured start phase. The strobe works in every cycle, whether or not the block is running. The output is a stream with valid/ready. All channels leave together as one beat, and a beat is accepted when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the samples and phases hold and no accumulator moves. `run_en` is a plain control pin. Dropping it abandons the stream: `out_valid` falls on the next edge and the accumulators freeze.

Top module: `qsg_bank`

## Requirements
- R1: After reset, `out_valid` is 0 and every sample and phase output is 0. Every accumulator is also 0.
- R2: When `run_en` is high and `out_valid` is low, `out_valid` goes to 1 on the next clock edge. When `run_en` is low, `out_valid` is 0 after the next edge, and the accumulators and outputs hold their values.
- R3: When `out_valid` is 1 and `out_ready` is 0, the next edge changes no sample, no phase output and no accumulator.
- R4: A beat is produced when `run_en` is high and either `out_ready` is high or `out_valid` is low. On each produced beat, a channel's accumulator advances by its frequency word, modulo 2^32.
- R5: The step is limited to 2^27, which guarantees at least 32 samples per period. A frequency word above 2^27 steps exactly 2^27.
- R6: A high `phase_rst` at an edge loads every channel's accumulator with that channel's `init_phase` word. This takes priority over stepping. The next beat produced carries the sample for that start phase.
- R7: Table entry i (0 to 255) holds round((2^23-1)·sin((i+0.5)·π/512)). The table index is accumulator bits [29:22]. Every magnitude is above zero, and the most negative 24-bit code never appears.
- R8: Accumulator bits [31:30] are the quadrant. In quadrants 1 and 3 the index is bit-inverted. In quadrants 2 and 3 the sample is negated in two's complement. Together these make each sample equal to round((2^23-1)·sin((k+0.5)·π/512)), where k = accumulator bits [31:22].
- R9: Each beat's 5-bit phase output for a channel equals bits [31:27] of the accumulator value its sample was made from.
- R10: The four channels are independent. Channel c uses bits [32c+31:32c] of the word buses, sample bits [24c+23:24c] and phase bits [5c+4:5c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable; low freezes accumulators and clears valid |
| phase_rst | input | 1 | Reload all accumulators with their start phases |
| freq_word | input | 128 | Per-channel frequency (step) words, 32 bits each |
| init_phase | input | 128 | Per-channel start phase words, 32 bits each |
| out_ready | input | 1 | Downstream accepts the current beat |
| out_valid | output | 1 | A beat of samples is presented |
| sample_out | output | 96 | Per-channel signed samples, 24 bits each |
| phase_out | output | 20 | Per-channel phase tags, 5 bits each |

## Verification
The bench places start phases exactly on quadrant boundaries and on both sides of them. A design with a wrong mirror or a wrong sign rule would produce a discontinuous wave, or a second half of the period that is not negated. It also drives frequency words far above the step limit. A missing clamp would produce large jumps in the phase tag. Stalls with ready low and stretches with run low check that nothing moves. A design that kept stepping would skip samples after the stall. Trigger reloads arrive both mid-run and while idle. A design that reloaded only while running, or reloaded only one channel, would show the wrong start sample.

// File: rtl/qsg_pkg.sv
package qsg_pkg;
  localparam real PI_R = 3.14159265358979323846;

  // Magnitude of quarter-table entry idx, half-step offset so the mirror is exact
  function automatic int quarter_mag(int idx, int addr_w, int mag_w);
    real full_r;
    real ang_r;
    full_r = real'((longint'(1) << mag_w) - 1);
    ang_r  = (real'(idx) + 0.5) * PI_R / (2.0 * real'(longint'(1) << addr_w));
    return $rtoi(full_r * $sin(ang_r) + 0.5);
  endfunction
endpackage

// File: rtl/qsg_quarter_rom.sv
module qsg_quarter_rom #(
  parameter int LUT_AW = 8,
  parameter int MAG_W  = 23
) (
  input  logic [LUT_AW-1:0] addr,
  output logic [MAG_W-1:0]  mag
);
  localparam int DEPTH = 1 << LUT_AW;

  logic [MAG_W-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    assign table_w[i] = MAG_W'(qsg_pkg::quarter_mag(i, LUT_AW, MAG_W));
  end

  assign mag = table_w[addr];
endmodule

// File: rtl/qsg_channel.sv
module qsg_channel #(
  parameter int ACC_W   = 32,
  parameter int LUT_AW  = 8,
  parameter int SAMP_W  = 24,
  parameter int PHOUT_W = 5,
  parameter int MIN_SPP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              reload,
  input  logic [ACC_W-1:0]  freq_word,
  input  logic [ACC_W-1:0]  init_phase,
  output logic [SAMP_W-1:0] sample,
  output logic [PHOUT_W-1:0] phase_tag
);
  localparam int SPP_LOG = $clog2(MIN_SPP);
  localparam logic [ACC_W-1:0] MAX_STEP = ACC_W'(1) << (ACC_W - SPP_LOG);
  localparam int MAG_W = SAMP_W - 1;

  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  step_w;
  logic [1:0]        quad_w;
  logic [LUT_AW-1:0] idx_w;
  logic [LUT_AW-1:0] rom_addr_w;
  logic [MAG_W-1:0]  mag_w;
  logic [SAMP_W-1:0] mag_ext_w;
  logic [SAMP_W-1:0] sample_d;

  // Step limit keeps at least MIN_SPP samples per period
  assign step_w = (freq_word > MAX_STEP) ? MAX_STEP : freq_word;

  assign quad_w     = acc_q[ACC_W-1 -: 2];
  assign idx_w      = acc_q[ACC_W-3 -: LUT_AW];
  assign rom_addr_w = quad_w[0] ? ~idx_w : idx_w;

  qsg_quarter_rom #(.LUT_AW(LUT_AW), .MAG_W(MAG_W)) u_rom (
    .addr (rom_addr_w),
    .mag  (mag_w)
  );

  assign mag_ext_w = {1'b0, mag_w};
  assign sample_d  = quad_w[1] ? (~mag_ext_w + SAMP_W'(1)) : mag_ext_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      sample    <= '0;
      phase_tag <= '0;
    end else begin
      if (reload)    acc_q <= init_phase;
      else if (fire) acc_q <= acc_q + step_w;
      if (fire) begin
        sample    <= sample_d;
        phase_tag <= acc_q[ACC_W-1 -: PHOUT_W];
      end
    end
  end
endmodule

// File: rtl/qsg_bank.sv
module qsg_bank #(
  parameter int NUM_CH  = 4,
  parameter int ACC_W   = 32,
  parameter int LUT_AW  = 8,
  parameter int SAMP_W  = 24,
  parameter int PHOUT_W = 5,
  parameter int MIN_SPP = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_en,
  input  logic                      phase_rst,
  input  logic [NUM_CH*ACC_W-1:0]   freq_word,
  input  logic [NUM_CH*ACC_W-1:0]   init_phase,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [NUM_CH*SAMP_W-1:0]  sample_out,
  output logic [NUM_CH*PHOUT_W-1:0] phase_out
);
  logic fire_w;

  // A beat is made when running and the previous one is gone or accepted
  assign fire_w = run_en & (out_ready | ~out_valid);

  always_ff @(posedge clk) begin
    if (!rst_n)       out_valid <= 1'b0;
    else if (!run_en) out_valid <= 1'b0;
    else if (fire_w)  out_valid <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qsg_channel #(
      .ACC_W(ACC_W), .LUT_AW(LUT_AW), .SAMP_W(SAMP_W),
      .PHOUT_W(PHOUT_W), .MIN_SPP(MIN_SPP)
    ) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire_w),
      .reload     (phase_rst),
      .freq_word  (freq_word[c*ACC_W +: ACC_W]),
      .init_phase (init_phase[c*ACC_W +: ACC_W]),
      .sample     (sample_out[c*SAMP_W +: SAMP_W]),
      .phase_tag  (phase_out[c*PHOUT_W +: PHOUT_W])
    );
  end
endmodule

// File: rtl/qsg_bank_chk.sv
module qsg_bank_chk #(
  parameter int NUM_CH  = 4,
  parameter int SAMP_W  = 24,
  parameter int PHOUT_W = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      run_en,
  input logic                      out_ready,
  input logic                      out_valid,
  input logic [NUM_CH*SAMP_W-1:0]  sample_out,
  input logic [NUM_CH*PHOUT_W-1:0] phase_out
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(sample_out) && $stable(phase_out))); // R3

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !out_valid); // R2

  AST_VALID_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !out_valid) |=> out_valid); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_SIGN_MATCHES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sample_out[c*SAMP_W + SAMP_W-1] == phase_out[c*PHOUT_W + PHOUT_W-1])); // R8

    AST_NO_MOST_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sample_out[c*SAMP_W +: SAMP_W] != {1'b1, {(SAMP_W-1){1'b0}}})); // R7
  end
endmodule

bind qsg_bank qsg_bank_chk #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W), .PHOUT_W(PHOUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .out_ready  (out_ready),
  .out_valid  (out_valid),
  .sample_out (sample_out),
  .phase_out  (phase_out)
);

// File: tb/qsg_bank_tb_top.sv
module qsg_bank_tb_top;
  localparam int NCH = 4;
  localparam real FULL = 8388607.0;
  localparam real PI_B = 3.14159265358979323846;
  localparam logic [31:0] STEP_CAP = 32'h0800_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic phase_rst = 1'b0;
  logic out_ready = 1'b0;
  logic [NCH*32-1:0] freq_word = '0;
  logic [NCH*32-1:0] init_phase = '0;
  logic out_valid;
  logic [NCH*24-1:0] sample_out;
  logic [NCH*5-1:0]  phase_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] acc_m [NCH];
  int          smp_m [NCH];
  logic [4:0]  ph_m  [NCH];
  logic        v_m;

  always #10 clk = ~clk;

  qsg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .phase_rst(phase_rst),
    .freq_word(freq_word), .init_phase(init_phase), .out_ready(out_ready),
    .out_valid(out_valid), .sample_out(sample_out), .phase_out(phase_out)
  );

  // Expected sample straight from the full-circle formula (R7, R8)
  function automatic int exp_sample(logic [31:0] a);
    real s;
    int  m;
    s = $sin((real'(a[31:22]) + 0.5) * PI_B / 512.0);
    if (s < 0.0) s = -s;
    m = $rtoi(FULL * s + 0.5);
    return a[31] ? -m : m;
  endfunction

  function automatic logic [31:0] capped(logic [31:0] f);
    return (f > STEP_CAP) ? STEP_CAP : f;
  endfunction

  task automatic check_int(string tag, int act, int exp, int tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check_int(tag, int'(out_valid), int'(v_m), 0);
    for (int c = 0; c < NCH; c++) begin
      check_int(tag, int'($signed(sample_out[c*24 +: 24])), smp_m[c], 1);
      check_int(tag, int'(phase_out[c*5 +: 5]), int'(ph_m[c]), 0);
    end
  endtask

  // One clock: update the model from the inputs held across the edge, check at negedge
  task automatic cyc(string tag);
    logic fire;
    @(posedge clk);
    fire = run_en && (out_ready || !v_m);
    for (int c = 0; c < NCH; c++) begin
      if (fire) begin
        smp_m[c] = exp_sample(acc_m[c]);
        ph_m[c]  = acc_m[c][31:27];
      end
      if (phase_rst)  acc_m[c] = init_phase[c*32 +: 32];
      else if (fire)  acc_m[c] = acc_m[c] + capped(freq_word[c*32 +: 32]);
    end
    v_m = run_en;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int c = 0; c < NCH; c++) begin
      acc_m[c] = '0; smp_m[c] = 0; ph_m[c] = '0;
    end
    v_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // Start phases on and around quadrant boundaries, distinct rates (R10)
    init_phase = {32'hC000_0000, 32'h8000_0000, 32'h3FC0_0000, 32'h4000_0000};
    freq_word  = {32'h0010_0000, 32'h0100_0000, 32'h0040_0000, 32'h0004_0000};
    phase_rst = 1'b1;
    cyc("R6 idle reload");
    phase_rst = 1'b0;
    run_en = 1'b1; out_ready = 1'b1;
    cyc("R2 valid rise");
    for (int i = 0; i < 60; i++) cyc("R4 R8 R9 R10 directed");

    run_en = 1'b0;
    repeat (3) cyc("R2 run low freeze");
    run_en = 1'b1;
    repeat (3) cyc("R2 restart");

    // Frequency words far past the cap
    freq_word = {32'hFFFF_FFFF, 32'h0800_0001, 32'h0800_0000, 32'h9000_0000};
    for (int i = 0; i < 70; i++) cyc("R5 step cap");

    out_ready = 1'b0;
    repeat (5) cyc("R3 stall");
    out_ready = 1'b1;
    repeat (3) cyc("R3 resume");

    phase_rst = 1'b1;
    cyc("R6 run reload");
    phase_rst = 1'b0;
    repeat (4) cyc("R6 after reload");

    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 49) == 0)
        for (int c = 0; c < NCH; c++) freq_word[c*32 +: 32] = ($urandom_range(0, 3) == 0) ? $urandom() : $urandom() >> 5;
      if ($urandom_range(0, 99) == 0)
        for (int c = 0; c < NCH; c++) init_phase[c*32 +: 32] = $urandom();
      phase_rst = ($urandom_range(0, 59) == 0);
      run_en    = ($urandom_range(0, 19) != 0);
      out_ready = ($urandom_range(0, 3) != 0);
      cyc("R4 R7 R8 R9 R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule